// File: doc/BRIEF.md
# Sub-word rotate and permute unit

This unit performs a family of 32-bit bit-manipulation operations on two operands, a destination-style operand `d_i` and a source-style operand `s_i`. The logic is combinational, and a single output register captures the result when `valid_i` is high. The rotate-insert operations shift `d_i` by a nibble, a byte or a half-word. The vacated end is filled with the field of `s_i` that `idx_i` selects. The unit also reverses nibble and byte order, and it de-interleaves or re-interleaves even and odd bits. It can encode the highest set bit, decode a 5-bit position into a one-hot word, and load both flags from a chosen pair of adjacent bits.

The unit fits in an execution stage next to a main ALU. The stage presents one operation per valid cycle and reads `result_o`, `z_o` and `c_o` one clock later. The outputs hold their value while `valid_i` is low.

Top module: `bitperm_unit`

## Requirements
- R1: While `rst_n` is low, `result_o`, `z_o` and `c_o` are zero. Outputs change only on a rising clock edge with `valid_i` high, one cycle after the operands are presented.
- R2: While `valid_i` is low, `result_o`, `z_o` and `c_o` keep their previous values, whatever the other inputs do.
- R3: Left rotate-insert with op 0 (nibble), op 1 (byte) or op 2 (half-word) gives `d_i` shifted left by 4, 8 or 16 bits, with the low bits filled by field number `idx_i` of `s_i`. The field is counted from bit 0. Only the low 3, 2 or 1 bits of `idx_i` are used. `c_o` takes `d_i[31]`.
- R4: Right rotate-insert with op 3 (nibble), op 4 (byte) or op 5 (half-word) gives `d_i` shifted right by 4, 8 or 16 bits, with the top bits filled by field number `idx_i` of `s_i`. The index is used as in R3. `c_o` takes `d_i[0]`.
- R5: Op 6 reverses the order of the eight nibbles of `d_i`. Applying op 6 and then op 7 to a word swaps the two nibbles within each byte.
- R6: Op 7 reverses the order of the four bytes of `d_i`.
- R7: Op 8 (split) puts bit 2i of `d_i` at result bit i and bit 2i+1 at result bit 16+i. Op 9 (merge) is its inverse, so merge applied to a split result returns the original word.
- R8: Op 10 returns the position of the most significant set bit of `d_i`. When `d_i` is zero, it returns 0 and sets `z_o`; otherwise `z_o` is 0.
- R9: Op 11 returns a word with exactly one bit set, at position `d_i[4:0]`.
- R10: Op 12 passes `d_i` through to `result_o` and loads `z_o` from `d_i[2k]` and `c_o` from `d_i[2k+1]`, where k = `s_i[3:0]`.
- R11: For every op except 10 and 12, `z_o` is 1 exactly when the result is zero. `c_o` is 0 for ops 6 to 11 and 13 to 15. Ops 13 to 15 pass `d_i` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the output register |
| op_i | input | 4 | Operation select |
| idx_i | input | 3 | Sub-field index for rotate-insert |
| d_i | input | 32 | Primary operand |
| s_i | input | 32 | Secondary operand (field source or pair index) |
| result_o | output | 32 | Registered result |
| z_o | output | 1 | Registered zero / picked flag |
| c_o | output | 1 | Registered carry / picked flag |

## Verification
The hardest behaviours to reach are the two compositions: nibble reversal followed by byte reversal, and split followed by merge. Each is a property of two operations in a row, not of one. The bench feeds each registered result back as the next `d_i` and compares the final word to the original or to its per-byte nibble swap. Random stimulus rarely gives a zero operand for top-bit, or the extreme pair and field indices, so these are driven directly. Ignored high index bits are checked by giving the same operation full 3-bit indices.

// File: rtl/bitperm_unit.sv
module bitperm_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [3:0]  op_i,
  input  logic [2:0]  idx_i,
  input  logic [31:0] d_i,
  input  logic [31:0] s_i,
  output logic [31:0] result_o,
  output logic        z_o,
  output logic        c_o
);

  logic [3:0]  nib_sel;
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic [31:0] res_c;
  logic        z_c, c_c;

  assign nib_sel  = s_i[idx_i*4 +: 4];
  assign byte_sel = s_i[idx_i[1:0]*8 +: 8];
  assign half_sel = s_i[idx_i[0]*16 +: 16];

  always_comb begin
    res_c = d_i;
    c_c   = 1'b0;
    z_c   = 1'b0;
    case (op_i)
      4'd0: begin res_c = {d_i[27:0], nib_sel};  c_c = d_i[31]; end
      4'd1: begin res_c = {d_i[23:0], byte_sel}; c_c = d_i[31]; end
      4'd2: begin res_c = {d_i[15:0], half_sel}; c_c = d_i[31]; end
      4'd3: begin res_c = {nib_sel, d_i[31:4]};  c_c = d_i[0]; end
      4'd4: begin res_c = {byte_sel, d_i[31:8]}; c_c = d_i[0]; end
      4'd5: begin res_c = {half_sel, d_i[31:16]}; c_c = d_i[0]; end
      4'd6: for (int i = 0; i < 8; i++) res_c[i*4 +: 4] = d_i[(7-i)*4 +: 4];
      4'd7: for (int i = 0; i < 4; i++) res_c[i*8 +: 8] = d_i[(3-i)*8 +: 8];
      4'd8: for (int i = 0; i < 16; i++) begin
              res_c[i]    = d_i[2*i];
              res_c[16+i] = d_i[2*i+1];
            end
      4'd9: for (int i = 0; i < 16; i++) begin
              res_c[2*i]   = d_i[i];
              res_c[2*i+1] = d_i[16+i];
            end
      4'd10: begin
               res_c = '0;
               for (int i = 0; i < 32; i++) if (d_i[i]) res_c = 32'(i);
             end
      4'd11: res_c = 32'd1 << d_i[4:0];
      4'd12: begin
               z_c = d_i[{s_i[3:0], 1'b0}];
               c_c = d_i[{s_i[3:0], 1'b1}];
             end
      default: res_c = d_i;
    endcase
    if (op_i == 4'd10)      z_c = (d_i == '0);
    else if (op_i != 4'd12) z_c = (res_c == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      z_o      <= 1'b0;
      c_o      <= 1'b0;
    end else if (valid_i) begin
      result_o <= res_c;
      z_o      <= z_c;
      c_o      <= c_c;
    end
  end

endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic [31:0] d_i,
  input logic [31:0] result_o,
  input logic        z_o,
  input logic        c_o
);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(z_o) && $stable(c_o)));

  assert_rotl_nib_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd0) |=> (result_o[31:4] == $past(d_i[27:0]) && c_o == $past(d_i[31])));

  assert_rotr_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd4) |=> (result_o[23:0] == $past(d_i[31:8]) && c_o == $past(d_i[0])));

  assert_byte_rev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd7) |=> (result_o[7:0] == $past(d_i[31:24])));

  assert_decode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd11) |=> ($countones(result_o) == 1));

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 4'd10 && op_i != 4'd12) |=> (z_o == (result_o == 32'd0)));

  assert_topbit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd10) |=> (z_o == ($past(d_i) == 32'd0)));

endmodule

bind bitperm_unit bitperm_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .d_i(d_i),
  .result_o(result_o), .z_o(z_o), .c_o(c_o)
);

// File: tb/test_bitperm_unit.sv
`timescale 1ns/1ps
module test_bitperm_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_i = 0;
  logic [3:0]  op_i = '0;
  logic [2:0]  idx_i = '0;
  logic [31:0] d_i = '0, s_i = '0;
  logic [31:0] result_o;
  logic        z_o, c_o;
  int compared = 0, mismatched = 0;
  logic [33:0] last_exp;

  bitperm_unit i_bitperm_unit (.*);

  always #10 clk = ~clk;

  function automatic logic [33:0] model(input logic [3:0] op, input logic [2:0] idx,
                                        input logic [31:0] d, input logic [31:0] s);
    logic [31:0] r; logic z, c; logic [3:0] nb; logic [7:0] by; logic [15:0] hw;
    nb = 4'((s >> (idx * 4)) & 32'hF);
    by = 8'((s >> (idx[1:0] * 8)) & 32'hFF);
    hw = idx[0] ? s[31:16] : s[15:0];
    r = d; c = 0;
    case (op)
      0: begin r = (d << 4) | 32'(nb); c = d[31]; end
      1: begin r = (d << 8) | 32'(by); c = d[31]; end
      2: begin r = (d << 16) | 32'(hw); c = d[31]; end
      3: begin r = (d >> 4) | (32'(nb) << 28); c = d[0]; end
      4: begin r = (d >> 8) | (32'(by) << 24); c = d[0]; end
      5: begin r = (d >> 16) | (32'(hw) << 16); c = d[0]; end
      6: begin r = 0; for (int k = 0; k < 8; k++) r |= ((d >> (4*k)) & 32'hF) << (4*(7-k)); end
      7: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      8: begin r = 0; for (int k = 0; k < 16; k++) begin r[k] = d[2*k]; r[16+k] = d[2*k+1]; end end
      9: begin r = 0; for (int k = 0; k < 16; k++) begin r[2*k] = d[k]; r[2*k+1] = d[16+k]; end end
      10: begin r = 0; for (int k = 31; k >= 0; k--) if (d[k] && r == 0 && k != 0) begin r = k; break; end end
      11: r = 32'h1 << d[4:0];
      12: ;
      default: r = d;
    endcase
    if (op == 10) z = (d == 0);
    else if (op == 12) begin z = d[2*s[3:0]]; c = d[2*s[3:0]+1]; end
    else z = (r == 0);
    return {r, z, c};
  endfunction

  task automatic check(input string req, input logic [33:0] exp);
    compared++;
    if ({result_o, z_o, c_o} !== exp) begin
      mismatched++;
      $display("FAIL %s: got res=%h z=%b c=%b expected res=%h z=%b c=%b",
               req, result_o, z_o, c_o, exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [2:0] idx,
                     input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    valid_i = 1; op_i = op; idx_i = idx; d_i = d; s_i = s;
    last_exp = model(op, idx, d, s);
    @(negedge clk);
    valid_i = 0;
    check(req, last_exp);
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] w, sp;
    void'($urandom(32'h5EED1234));
    d_i = 32'hFFFF_FFFF; valid_i = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 34'd0);
    valid_i = 0; rst_n = 1;
    @(negedge clk);
    check("R1 after release idle", 34'd0);

    run("R3 rotl nib", 0, 3'd7, 32'h8123_4567, 32'hA000_0000);
    run("R3 rotl byte idx high bit ignored", 1, 3'd6, 32'h0000_00FF, 32'h11_22_33_44);
    run("R3 rotl half", 2, 3'd1, 32'h1234_5678, 32'hBEEF_0000);
    run("R4 rotr nib", 3, 3'd0, 32'h0000_0001, 32'h0000_000C);
    run("R4 rotr byte", 4, 3'd3, 32'h1234_5678, 32'hAB00_0000);
    run("R4 rotr half idx", 5, 3'd2, 32'hFFFF_0000, 32'h0000_0000);

    @(negedge clk);
    valid_i = 0; op_i = 4'd11; d_i = 32'h1F; s_i = $urandom;
    @(negedge clk);
    check("R2 hold while idle", last_exp);

    run("R5 nibble reverse", 6, 0, 32'h1234_5678, 0);
    run("R5 compose byte reverse", 7, 0, result_o, 0);
    check("R5 per-byte nibble swap", {32'h2143_6587, 1'b0, 1'b0});
    run("R6 byte reverse", 7, 0, 32'hDEAD_BEEF, 0);

    w = 32'hC0FF_EE15;
    run("R7 split", 8, 0, w, 0);
    sp = result_o;
    run("R7 merge", 9, 0, sp, 0);
    check("R7 merge inverts split", {w, 1'b0, 1'b0});

    run("R8 topbit zero", 10, 0, 32'h0, 0);
    run("R8 topbit one", 10, 0, 32'h1, 0);
    run("R8 topbit msb", 10, 0, 32'h8000_0001, 0);
    run("R9 decode 31", 11, 0, 32'hFFFF_FFFF, 0);
    run("R9 decode 0", 11, 0, 32'h20, 0);
    run("R10 pick pair 15", 12, 0, 32'h8000_0000, 32'hF);
    run("R10 pick pair 0", 12, 0, 32'h0000_0001, 32'hFFFF_FFF0);
    run("R11 pass-through zero", 13, 0, 32'h0, 0);
    run("R11 zero rotate", 0, 0, 32'h0, 32'h0);

    for (int n = 0; n < 400; n++)
      run("R11 random", 4'($urandom), 3'($urandom), $urandom, $urandom);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule